// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Software/Hardware Ownership

This block is a bank of general-purpose pins, up to 32 of them, where each pin is owned either by an internal hardware function or by software. A per-pin ownership bit selects the pad drive. When the bit is 0, the hardware function's output-enable and data bits go to the pad. When it is 1, the software output-enable and data-out registers drive the pad instead. The ownership, output-enable and data-out states can only be changed through paired set and clear addresses. Software therefore alters single pins without a read-modify-write sequence.

Pad inputs pass through a two-flop synchroniser before they can be read. For a pin that software owns and drives as an output, the pad-input read returns the value being driven, so its direction does not have to change. A change of ownership reaches the pad one cycle later than a change of output-enable or data-out. This lets software write the data value first and then take the pin without a glitch.

Top module: `gpio_own_bank`

## Requirements
- R1: After reset, the ownership, output-enable and data-out registers read as 0. Every pad then shows the hardware function's output-enable and data.
- R2: A write to 0x00 (ownership), 0x04 (output enable) or 0x08 (data out) sets each register bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to 0x14 (ownership), 0x18 (output enable) or 0x1C (data out) clears each register bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Reads are combinational from `bus_addr`. Address 0x34 returns output enable, 0x38 returns data out and 0x44 returns ownership, each in the same cycle.
- R5: For a pin whose effective ownership bit is 0, `pad_oe`/`pad_do` equal `hw_oe`/`hw_do`. For a pin whose effective ownership bit is 1, they equal the software output-enable and data-out bits.
- R6: An output-enable or data-out write reaches the pad at the clock edge that ends the write cycle. An ownership write updates the register at that edge but reaches the pad only at the following edge.
- R7: Address 0x30 returns the pad input through a two-flop synchroniser. A change of `pad_di` becomes visible after the second rising edge, not after the first.
- R8: For a pin that is software-owned (effective ownership 1) with output enable 1, the 0x30 bit returns that pin's data-out bit, whatever `pad_di` is.
- R9: Reads of the set, clear and unmapped addresses return 0. Writes to the read-back addresses 0x30, 0x34, 0x38 and 0x44, and to unmapped addresses, change no register.
- R10: Write-data bits at and above `NPINS` are ignored, and read-back bits at and above `NPINS` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wr | input | 1 | Write strobe, acts at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| hw_oe | input | NPINS | Hardware-function output enable per pin |
| hw_do | input | NPINS | Hardware-function output data per pin |
| pad_oe | output | NPINS | Pad output enable |
| pad_do | output | NPINS | Pad output data |
| pad_di | input | NPINS | Pad input level (asynchronous) |

## Verification
The hardest point to observe is the one-cycle gap between an ownership write landing in its register and reaching the pad. During that cycle the 0x44 read-back already shows the new value while the pad still follows the hardware function. The bench writes ownership and samples the pads at the negative edge right after the write. It then samples again one edge later, with `hw_oe`/`hw_do` set to a pattern that differs from the software registers, so that a pad with no delay or a pad with two cycles of delay can both be seen. The synchroniser depth is checked the same way: `pad_di` is changed, and 0x30 is read after one edge and again after two.

// File: rtl/gpio_own_pkg.sv
package gpio_own_pkg;
  localparam int BUS_W  = 32;
  localparam int ADDR_W = 8;

  // write-one-to-set addresses
  localparam logic [ADDR_W-1:0] A_OWN_SET = 8'h00;
  localparam logic [ADDR_W-1:0] A_OE_SET  = 8'h04;
  localparam logic [ADDR_W-1:0] A_DO_SET  = 8'h08;
  // write-one-to-clear addresses
  localparam logic [ADDR_W-1:0] A_OWN_CLR = 8'h14;
  localparam logic [ADDR_W-1:0] A_OE_CLR  = 8'h18;
  localparam logic [ADDR_W-1:0] A_DO_CLR  = 8'h1C;
  // read-back addresses
  localparam logic [ADDR_W-1:0] A_PIN_RD  = 8'h30;
  localparam logic [ADDR_W-1:0] A_OE_RD   = 8'h34;
  localparam logic [ADDR_W-1:0] A_DO_RD   = 8'h38;
  localparam logic [ADDR_W-1:0] A_OWN_RD  = 8'h44;

  // field index inside the set/clear register array
  localparam int F_OWN = 0;
  localparam int F_OE  = 1;
  localparam int F_DO  = 2;
  localparam int NFIELD = 3;

  function automatic logic [ADDR_W-1:0] set_addr(input int f);
    case (f)
      F_OWN:   return A_OWN_SET;
      F_OE:    return A_OE_SET;
      default: return A_DO_SET;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] clr_addr(input int f);
    case (f)
      F_OWN:   return A_OWN_CLR;
      F_OE:    return A_OE_CLR;
      default: return A_DO_CLR;
    endcase
  endfunction

  // next value of a set/clear register for one bus write
  function automatic logic [BUS_W-1:0] setclr_next(input logic [BUS_W-1:0] cur,
                                                   input logic [BUS_W-1:0] bits,
                                                   input logic do_set,
                                                   input logic do_clr);
    logic [BUS_W-1:0] r;
    r = cur;
    if (do_set) r = r | bits;
    if (do_clr) r = r & ~bits;
    return r;
  endfunction
endpackage

// File: rtl/gpio_own_setclr.sv
module gpio_own_setclr
  import gpio_own_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [BUS_W-1:0] nxt;

  always_comb begin
    nxt = setclr_next(BUS_W'(q), BUS_W'(bits), set_stb, clr_stb);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= nxt[W-1:0];
  end
endmodule

// File: rtl/gpio_own_sync.sv
module gpio_own_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1   <= '0;
      sync_out <= '0;
    end else begin
      stage1   <= async_in;
      sync_out <= stage1;
    end
  end
endmodule

// File: rtl/gpio_own_mux.sv
module gpio_own_mux #(
  parameter int W = 32
) (
  input  logic [W-1:0] own,
  input  logic [W-1:0] sw_oe,
  input  logic [W-1:0] sw_do,
  input  logic [W-1:0] hw_oe,
  input  logic [W-1:0] hw_do,
  input  logic [W-1:0] pin_sync,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do,
  output logic [W-1:0] pin_view
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    logic sw_drives;
    assign sw_drives   = own[i] & sw_oe[i];
    assign pad_oe[i]   = own[i] ? sw_oe[i] : hw_oe[i];
    assign pad_do[i]   = own[i] ? sw_do[i] : hw_do[i];
    assign pin_view[i] = sw_drives ? sw_do[i] : pin_sync[i];
  end
endmodule

// File: rtl/gpio_own_bank.sv
module gpio_own_bank
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPINS-1:0]  hw_oe,
  input  logic [NPINS-1:0]  hw_do,
  output logic [NPINS-1:0]  pad_oe,
  output logic [NPINS-1:0]  pad_do,
  input  logic [NPINS-1:0]  pad_di
);
  localparam int W = NPINS;

  logic [NFIELD-1:0]        set_stb;
  logic [NFIELD-1:0]        clr_stb;
  logic [NFIELD-1:0][W-1:0] field_q;
  logic [W-1:0]             wbits;

  // named events for the checker
  logic         wr_own_set, wr_own_clr, wr_oe_set, wr_oe_clr, wr_do_set, wr_do_clr;
  logic [W-1:0] own_q, oe_q, do_q;
  logic [W-1:0] own_eff;
  logic [W-1:0] pin_sync, pin_view;

  assign wbits = bus_wdata[W-1:0];

  for (genvar f = 0; f < NFIELD; f++) begin : g_field
    assign set_stb[f] = bus_wr && (bus_addr == set_addr(f));
    assign clr_stb[f] = bus_wr && (bus_addr == clr_addr(f));

    gpio_own_setclr #(.W(W)) reg_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_stb (set_stb[f]),
      .clr_stb (clr_stb[f]),
      .bits    (wbits),
      .q       (field_q[f])
    );
  end

  assign own_q      = field_q[F_OWN];
  assign oe_q       = field_q[F_OE];
  assign do_q       = field_q[F_DO];
  assign wr_own_set = set_stb[F_OWN];
  assign wr_own_clr = clr_stb[F_OWN];
  assign wr_oe_set  = set_stb[F_OE];
  assign wr_oe_clr  = clr_stb[F_OE];
  assign wr_do_set  = set_stb[F_DO];
  assign wr_do_clr  = clr_stb[F_DO];

  // ownership reaches the pad one cycle after its register, so a
  // data-out written just before the take-over is already in place
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) own_eff <= '0;
    else        own_eff <= own_q;
  end

  gpio_own_sync #(.W(W)) sync_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pad_di),
    .sync_out (pin_sync)
  );

  gpio_own_mux #(.W(W)) mux_i (
    .own      (own_eff),
    .sw_oe    (oe_q),
    .sw_do    (do_q),
    .hw_oe    (hw_oe),
    .hw_do    (hw_do),
    .pin_sync (pin_sync),
    .pad_oe   (pad_oe),
    .pad_do   (pad_do),
    .pin_view (pin_view)
  );

  always_comb begin
    case (bus_addr)
      A_PIN_RD: bus_rdata = 32'(pin_view);
      A_OE_RD:  bus_rdata = 32'(oe_q);
      A_DO_RD:  bus_rdata = 32'(do_q);
      A_OWN_RD: bus_rdata = 32'(own_q);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_own_bank_chk.sv
module gpio_own_bank_chk
  import gpio_own_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       bus_addr,
  input logic [31:0]      bus_wdata,
  input logic [31:0]      bus_rdata,
  input logic [NPINS-1:0] hw_oe,
  input logic [NPINS-1:0] hw_do,
  input logic [NPINS-1:0] pad_oe,
  input logic [NPINS-1:0] pad_do,
  input logic [NPINS-1:0] own_q,
  input logic [NPINS-1:0] own_eff,
  input logic [NPINS-1:0] oe_q,
  input logic [NPINS-1:0] do_q,
  input logic             wr_own_set,
  input logic             wr_own_clr,
  input logic             wr_oe_set,
  input logic             wr_oe_clr,
  input logic             wr_do_set,
  input logic             wr_do_clr
);
  logic [NPINS-1:0] wb;
  logic             rd_mapped;
  assign wb = bus_wdata[NPINS-1:0];
  assign rd_mapped = (bus_addr == A_PIN_RD) || (bus_addr == A_OE_RD) ||
                     (bus_addr == A_DO_RD)  || (bus_addr == A_OWN_RD);

  p_hw_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~own_eff) & ((pad_oe ^ hw_oe) | (pad_do ^ hw_do))) == '0);

  p_sw_pad_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (own_eff & ((pad_oe ^ oe_q) | (pad_do ^ do_q))) == '0);

  p_oe_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oe_set |=> ((~oe_q) & $past(wb)) == '0);

  p_do_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_do_set |=> ((~do_q) & $past(wb)) == '0);

  p_do_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_do_clr |=> (do_q & $past(wb)) == '0);

  p_oe_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oe_clr |=> ((oe_q ^ $past(oe_q)) & ~$past(wb)) == '0);

  p_own_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_own_clr |=> (own_q & $past(wb)) == '0);

  p_own_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_own_set |=> ($past(~own_q) & $past(wb) & own_eff) == '0);

  p_own_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_own_set ##1 !wr_own_clr |=> ((~own_eff) & $past(wb, 2)) == '0);

  p_loopback_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_PIN_RD) |-> ((bus_rdata[NPINS-1:0] ^ pad_do) & pad_oe & own_eff) == '0);

  p_rd_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mapped |-> bus_rdata == '0);

  if (NPINS < 32) begin : g_upper
    p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata[31:NPINS] == '0);
  end
endmodule

bind gpio_own_bank gpio_own_bank_chk #(.NPINS(NPINS)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .hw_oe      (hw_oe),
  .hw_do      (hw_do),
  .pad_oe     (pad_oe),
  .pad_do     (pad_do),
  .own_q      (own_q),
  .own_eff    (own_eff),
  .oe_q       (oe_q),
  .do_q       (do_q),
  .wr_own_set (wr_own_set),
  .wr_own_clr (wr_own_clr),
  .wr_oe_set  (wr_oe_set),
  .wr_oe_clr  (wr_oe_clr),
  .wr_do_set  (wr_do_set),
  .wr_do_clr  (wr_do_clr)
);

// File: tb/gpio_own_bank_tb_top.sv
module gpio_own_bank_tb_top;
  localparam int N = 24;
  localparam logic [31:0] M = 32'h00FF_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  hw_oe = '0;
  logic [N-1:0]  hw_do = '0;
  logic [N-1:0]  pad_oe, pad_do;
  logic [N-1:0]  pad_di = '0;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;   // 0 read data, 1 pad_oe, 2 pad_do
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  // bench-side model of the registers
  logic [31:0] m_own = '0, m_oe = '0, m_do = '0;

  always #4 clk = ~clk;

  gpio_own_bank #(.NPINS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_oe(hw_oe), .hw_do(hw_do),
    .pad_oe(pad_oe), .pad_do(pad_do), .pad_di(pad_di)
  );

  function automatic logic [31:0] pick(input logic [31:0] own, input logic [31:0] sw,
                                       input logic [31:0] hw);
    return ((own & sw) | (~own & hw)) & M;
  endfunction

  function automatic logic [31:0] pin_exp(input logic [31:0] own, input logic [31:0] oe,
                                          input logic [31:0] dout, input logic [31:0] pin);
    logic [31:0] drv;
    drv = own & oe;
    return ((drv & dout) | (~drv & pin)) & M;
  endfunction

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      item_t it;
      logic [31:0] act;
      wait (sb.size() > 0);
      #1;
      it = sb[0];
      case (it.kind)
        0:       act = bus_rdata;
        1:       act = 32'(pad_oe);
        default: act = 32'(pad_do);
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
      end
      void'(sb.pop_front());
    end
  end

  task automatic push(input int kind, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
  endtask

  task automatic chk_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    push(0, e, tag);
  endtask

  task automatic chk_pads(input logic [31:0] eoe, input logic [31:0] edo, input string tag);
    push(1, eoe, tag);
    push(2, edo, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      8'h00: m_own = m_own | (d & M);
      8'h04: m_oe  = m_oe  | (d & M);
      8'h08: m_do  = m_do  | (d & M);
      8'h14: m_own = m_own & ~d;
      8'h18: m_oe  = m_oe  & ~d;
      8'h1C: m_do  = m_do  & ~d;
      default: ;
    endcase
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] own_old;
    hw_oe = 24'hA5A5A5;
    hw_do = 24'h123456;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_rd(8'h34, 32'h0, "R1 oe after reset");
    chk_rd(8'h38, 32'h0, "R1 do after reset");
    chk_rd(8'h44, 32'h0, "R1 own after reset");
    chk_pads(32'(hw_oe), 32'(hw_do), "R1 pads follow hw after reset");

    // R2 set, R10 upper bits ignored
    wr(8'h04, 32'hFF00_FF00);
    chk_rd(8'h34, m_oe, "R2 oe set / R10 upper ignored");
    wr(8'h04, 32'h0000_00F0);
    chk_rd(8'h34, m_oe, "R2 oe set keeps zeros");
    wr(8'h08, 32'h0000_AAF0);
    chk_rd(8'h38, m_do, "R2 do set");

    // R3 clear
    wr(8'h1C, 32'h0000_A000);
    chk_rd(8'h38, m_do, "R3 do clear");
    wr(8'h18, 32'h0000_0F00);
    chk_rd(8'h34, m_oe, "R3 oe clear");
    chk_pads(32'(hw_oe), 32'(hw_do), "R5 hw owned pads");

    // R6 ownership is one cycle late, oe/do are not
    own_old = m_own;
    wr(8'h00, 32'h0000_FFFF);
    chk_pads(pick(own_old, m_oe, 32'(hw_oe)), pick(own_old, m_do, 32'(hw_do)),
             "R6 pads not yet switched");
    @(negedge clk);
    chk_pads(pick(m_own, m_oe, 32'(hw_oe)), pick(m_own, m_do, 32'(hw_do)),
             "R6 R5 pads switched to sw");
    chk_rd(8'h44, m_own, "R4 own read-back");
    wr(8'h08, 32'h0000_0100);
    chk_pads(pick(m_own, m_oe, 32'(hw_oe)), pick(m_own, m_do, 32'(hw_do)),
             "R6 do write reaches pad at once");

    // R9 reads of set/clear/unmapped, writes to read-back addresses
    chk_rd(8'h00, 32'h0, "R9 read of set address");
    chk_rd(8'h14, 32'h0, "R9 read of clear address");
    chk_rd(8'h20, 32'h0, "R9 read of unmapped address");
    wr(8'h44, 32'hFFFF_FFFF);
    wr(8'h34, 32'h0);
    wr(8'h38, 32'hFFFF_FFFF);
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h24, 32'hFFFF_FFFF);
    chk_rd(8'h44, m_own, "R9 own untouched");
    chk_rd(8'h34, m_oe, "R9 oe untouched");
    chk_rd(8'h38, m_do, "R9 do untouched");

    // R7 two-flop latency, R8 loopback of driven pins
    pad_di = 24'hC3C3C3;
    chk_rd(8'h30, pin_exp(m_own, m_oe, m_do, 32'h0), "R7 one edge: old value");
    chk_rd(8'h30, pin_exp(m_own, m_oe, m_do, 32'hC3C3C3), "R7 two edges: new value");
    pad_di = 24'h3C3C3C;
    @(negedge clk);
    chk_rd(8'h30, pin_exp(m_own, m_oe, m_do, 32'h3C3C3C), "R8 driven pins keep do");

    // R3 hand back to hardware
    wr(8'h18, 32'h0000_FFFF);
    wr(8'h14, 32'h0000_FFFF);
    chk_rd(8'h44, 32'h0, "R3 own clear");
    @(negedge clk);
    chk_pads(32'(hw_oe), 32'(hw_do), "R5 pads back to hw");
    chk_rd(8'h30, 32'h3C3C3C, "R10 pin read upper bits zero");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule